// File: doc/BRIEF.md
# Exception Vector Address Generator

This block works out the address a processor core fetches from when it takes an exception or an interrupt. The pipeline presents an exception class together with a one-cycle take strobe. One cycle later the block returns the entry address and a valid pulse. The address depends on a boot-vector bit, an interrupt-vector bit, an external-controller mode flag and a vector-spacing field.

The boot-vector bit lives inside the block. Reset sets it to 1, and a write port changes it. While the bit is 1, OS-handled entries sit in the uncached boot ROM window. When it is cleared, they move to the cached kernel region. The cache-error entry is the exception: it always stays on an uncached path. Reset, NMI and debug entries always go to the fixed ROM location.

In external-controller mode the block snapshots the 6-bit requested level when the exception is taken and keeps that snapshot until the next exception. With vectoring on, it uses the snapshot, scaled by the spacing, as the interrupt vector index. In the same mode the software-interrupt bits, the timer line, the performance-counter line and the debug-channel line are driven out as separate request signals. Without external mode, vectored interrupts take their index from the highest pending internal line.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset the boot-vector bit is 1, `cap_level` is 0, `vec_valid` is 0 and `vec_addr` is 0xBFC0_0000.
- R2: Classes reset (0), NMI (1) and debug (2) always give 0xBFC0_0000, whatever the boot-vector bit.
- R3: TLB refill (class 4) gives base+0x000 and general (class 6, also class 7) gives base+0x180. The base is 0xBFC0_0000 when the boot-vector bit is 1 and 0x8000_0000 when it is 0.
- R4: Cache error (class 3) gives 0xBFC0_0100 when the boot-vector bit is 1 and 0xA000_0100 when it is 0.
- R5: An interrupt (class 5) with `int_vec`=0 goes to the general entry, base+0x180.
- R6: An interrupt with `int_vec`=1 and `ext_mode`=1 goes to base+0x200+`ext_level`×step, using `ext_level` as sampled at the take. The step is 32, 64, 128, 256 or 512 bytes for `spacing` 1 to 5, and 0 for `spacing` 0, 6 or 7.
- R7: On each take, `cap_level` loads `ext_level` if `ext_mode`=1, or 0 otherwise. It is visible the cycle after the take and otherwise holds, whatever `ext_level` does.
- R8: An interrupt with `int_vec`=1 and `ext_mode`=0 goes to base+0x200+idx×step. Here idx is the position of the highest set bit of the 8-bit pending vector {hw_irq[5]|timer_irq|perf_irq|fdc_irq, hw_irq[4:0], sw_bits[1:0]}, and 0 if no bit is set.
- R9: With `ext_mode`=1, `sw_req`, `timer_req`, `perf_req` and `fdc_req` follow `sw_bits`, `timer_irq`, `perf_irq` and `fdc_irq` in the same cycle, and `sw_bits` has no effect on the vector. With `ext_mode`=0 these four outputs are 0.
- R10: `vec_valid` is 1 exactly in the cycle after each take, including back-to-back takes. `vec_addr` holds between takes.
- R11: A write with `bev_we`=1 sets the boot-vector bit to `bev_wd` from the next cycle on, and later takes follow the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_class | input | 3 | Exception class code |
| take_exc | input | 1 | Take-exception strobe |
| bev_we | input | 1 | Boot-vector bit write enable |
| bev_wd | input | 1 | Boot-vector bit write value |
| int_vec | input | 1 | Send interrupts to the special entry |
| ext_mode | input | 1 | External interrupt controller mode |
| spacing | input | 3 | Vector spacing code |
| ext_level | input | 6 | Requested level from the external controller |
| hw_irq | input | 6 | Internal hardware interrupt lines |
| sw_bits | input | 2 | Software interrupt bits |
| timer_irq | input | 1 | Timer interrupt |
| perf_irq | input | 1 | Performance-counter overflow interrupt |
| fdc_irq | input | 1 | Fast debug channel interrupt |
| vec_addr | output | 32 | Entry address |
| vec_valid | output | 1 | Entry address produced this cycle |
| cap_level | output | 6 | Captured interrupt level |
| sw_req | output | 2 | Software interrupt requests (external mode) |
| timer_req | output | 1 | Timer request out (external mode) |
| perf_req | output | 1 | Performance-counter request out (external mode) |
| fdc_req | output | 1 | Debug channel request out (external mode) |

## Verification
Every class is taken under both boot-vector values. This separates the fixed ROM entries, the relocatable entries and the always-uncached cache-error entry. Vectored interrupts are swept over all eight spacing codes with levels 0, 5, 37 and 63, in both external and internal mode. This tells the shift from the base, catches an out-of-range code, and catches the top level bit being lost. Internal pending patterns with one line, several lines and none show that the highest line wins and that the timer, performance and debug lines fold into the top line. The level is held while `ext_level` moves, the software bits are changed in external mode, and takes run back to back, so the snapshot is checked against the live input.

// File: rtl/evg_pkg.sv
package evg_pkg;
  typedef enum logic [2:0] {
    EXC_RESET      = 3'd0,
    EXC_NMI        = 3'd1,
    EXC_DEBUG      = 3'd2,
    EXC_CACHE_ERR  = 3'd3,
    EXC_TLB_REFILL = 3'd4,
    EXC_INTERRUPT  = 3'd5,
    EXC_GENERAL    = 3'd6,
    EXC_SPARE      = 3'd7
  } exc_class_e;
endpackage

// File: rtl/evg_irq_route.sv
module evg_irq_route #(
  parameter int unsigned HW_IRQ = 6,
  parameter int unsigned SW_IRQ = 2,
  parameter int unsigned IDX_W  = $clog2(HW_IRQ + SW_IRQ)
) (
  input  logic              ext_mode,
  input  logic [HW_IRQ-1:0] hw_irq,
  input  logic [SW_IRQ-1:0] sw_bits,
  input  logic              timer_irq,
  input  logic              perf_irq,
  input  logic              fdc_irq,
  output logic [SW_IRQ-1:0] sw_req,
  output logic              timer_req,
  output logic              perf_req,
  output logic              fdc_req,
  output logic [IDX_W-1:0]  int_idx
);
  localparam int unsigned NLINES = HW_IRQ + SW_IRQ;

  logic [NLINES-1:0] pending;

  // Internal-mode pending vector: shared lines fold onto the top hardware line.
  always_comb begin
    pending                = {hw_irq, sw_bits};
    pending[NLINES-1]      = hw_irq[HW_IRQ-1] | timer_irq | perf_irq | fdc_irq;
  end

  // Priority encoder: highest set position wins.
  always_comb begin
    int_idx = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (pending[i]) int_idx = IDX_W'(i);
    end
  end

  // Outward request lines exist only in external-controller mode.
  always_comb begin
    sw_req    = ext_mode ? sw_bits : '0;
    timer_req = ext_mode & timer_irq;
    perf_req  = ext_mode & perf_irq;
    fdc_req   = ext_mode & fdc_irq;
  end
endmodule

// File: rtl/evg_state_regs.sv
module evg_state_regs #(
  parameter int unsigned LEVEL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_exc,
  input  logic               ext_mode,
  input  logic [LEVEL_W-1:0] ext_level,
  input  logic               bev_we,
  input  logic               bev_wd,
  output logic               bev_q,
  output logic [LEVEL_W-1:0] level_q
);
  logic               bev_d;
  logic               bev_en;
  logic [LEVEL_W-1:0] level_d;
  logic               level_en;

  always_comb begin
    bev_en   = bev_we;
    bev_d    = bev_wd;
    level_en = take_exc;
    level_d  = ext_mode ? ext_level : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bev_q   <= 1'b1;
      level_q <= '0;
    end else begin
      if (bev_en)   bev_q   <= bev_d;
      if (level_en) level_q <= level_d;
    end
  end

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |=> $stable(level_q)); // R7
  AST_LEVEL_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && ext_mode) |=> (level_q == $past(ext_level))); // R7
  AST_BEV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bev_we |=> (bev_q == $past(bev_wd))); // R11
endmodule

// File: rtl/evg_addr_calc.sv
module evg_addr_calc
  import evg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEVEL_W   = 6,
  parameter int unsigned SPACE_W   = 3,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned MAX_SPACE = 5,
  parameter logic [ADDR_W-1:0] ROM_BASE      = ADDR_W'(32'hBFC0_0000),
  parameter logic [ADDR_W-1:0] CACHED_BASE   = ADDR_W'(32'h8000_0000),
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = ADDR_W'(32'hA000_0000),
  parameter logic [ADDR_W-1:0] OFF_TLB       = ADDR_W'(12'h000),
  parameter logic [ADDR_W-1:0] OFF_CERR      = ADDR_W'(12'h100),
  parameter logic [ADDR_W-1:0] OFF_GENERAL   = ADDR_W'(12'h180),
  parameter logic [ADDR_W-1:0] OFF_SPECIAL   = ADDR_W'(12'h200)
) (
  input  logic [2:0]         exc_class,
  input  logic               bev,
  input  logic               int_vec,
  input  logic               ext_mode,
  input  logic [SPACE_W-1:0] spacing,
  input  logic [LEVEL_W-1:0] level,
  input  logic [IDX_W-1:0]   int_idx,
  output logic [ADDR_W-1:0]  addr
);
  // Spacing code 1 means 32 bytes = 1 << 5, so shift = code + 4.
  localparam int unsigned SHIFT_BIAS = 4;
  localparam int unsigned SHAMT_W    = $clog2(MAX_SPACE + SHIFT_BIAS + 1);

  exc_class_e        cls;
  logic              space_ok;
  logic [SHAMT_W-1:0] shamt;
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] vec_off;
  logic [ADDR_W-1:0] os_base;
  logic [ADDR_W-1:0] cerr_base;

  always_comb begin
    cls       = exc_class_e'(exc_class);
    space_ok  = (spacing != '0) && (spacing <= SPACE_W'(MAX_SPACE));
    shamt     = SHAMT_W'(spacing) + SHAMT_W'(SHIFT_BIAS);
    idx_ext   = ext_mode ? ADDR_W'(level) : ADDR_W'(int_idx);
    vec_off   = space_ok ? (idx_ext << shamt) : '0;
    os_base   = bev ? ROM_BASE : CACHED_BASE;
    cerr_base = bev ? ROM_BASE : UNCACHED_BASE;
  end

  always_comb begin
    case (cls)
      EXC_RESET, EXC_NMI, EXC_DEBUG: addr = ROM_BASE;
      EXC_CACHE_ERR:                 addr = cerr_base + OFF_CERR;
      EXC_TLB_REFILL:                addr = os_base + OFF_TLB;
      EXC_INTERRUPT:                 addr = int_vec ? (os_base + OFF_SPECIAL + vec_off)
                                                    : (os_base + OFF_GENERAL);
      default:                       addr = os_base + OFF_GENERAL;
    endcase
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import evg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEVEL_W = 6,
  parameter int unsigned SPACE_W = 3,
  parameter int unsigned HW_IRQ  = 6,
  parameter int unsigned SW_IRQ  = 2,
  parameter logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(32'hBFC0_0000)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         exc_class,
  input  logic               take_exc,
  input  logic               bev_we,
  input  logic               bev_wd,
  input  logic               int_vec,
  input  logic               ext_mode,
  input  logic [SPACE_W-1:0] spacing,
  input  logic [LEVEL_W-1:0] ext_level,
  input  logic [HW_IRQ-1:0]  hw_irq,
  input  logic [SW_IRQ-1:0]  sw_bits,
  input  logic               timer_irq,
  input  logic               perf_irq,
  input  logic               fdc_irq,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic               vec_valid,
  output logic [LEVEL_W-1:0] cap_level,
  output logic [SW_IRQ-1:0]  sw_req,
  output logic               timer_req,
  output logic               perf_req,
  output logic               fdc_req
);
  localparam int unsigned IDX_W = $clog2(HW_IRQ + SW_IRQ);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic             bev_q;
  logic [IDX_W-1:0] int_idx;
  logic [ADDR_W-1:0] addr_calc;

  evg_irq_route #(.HW_IRQ(HW_IRQ), .SW_IRQ(SW_IRQ), .IDX_W(IDX_W)) u_route (
    .ext_mode (ext_mode),
    .hw_irq   (hw_irq),
    .sw_bits  (sw_bits),
    .timer_irq(timer_irq),
    .perf_irq (perf_irq),
    .fdc_irq  (fdc_irq),
    .sw_req   (sw_req),
    .timer_req(timer_req),
    .perf_req (perf_req),
    .fdc_req  (fdc_req),
    .int_idx  (int_idx)
  );

  evg_state_regs #(.LEVEL_W(LEVEL_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .take_exc (take_exc),
    .ext_mode (ext_mode),
    .ext_level(ext_level),
    .bev_we   (bev_we),
    .bev_wd   (bev_wd),
    .bev_q    (bev_q),
    .level_q  (cap_level)
  );

  evg_addr_calc #(
    .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W), .SPACE_W(SPACE_W), .IDX_W(IDX_W),
    .ROM_BASE(ROM_BASE)
  ) u_calc (
    .exc_class(exc_class),
    .bev      (bev_q),
    .int_vec  (int_vec),
    .ext_mode (ext_mode),
    .spacing  (spacing),
    .level    (ext_level),
    .int_idx  (int_idx),
    .addr     (addr_calc)
  );

  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              valid_d;

  always_comb begin
    addr_en = take_exc;
    addr_d  = addr_calc;
    valid_d = take_exc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vec_addr  <= ROM_BASE;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= valid_d;
      if (addr_en) vec_addr <= addr_d;
    end
  end

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_int_n)
    take_exc |=> vec_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_int_n)
    !take_exc |=> (!vec_valid && $stable(vec_addr))); // R10
  AST_FIXED_ROM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take_exc && (exc_class <= 3'd2)) |=> (vec_addr == ROM_BASE)); // R2
  AST_CERR_UNCACHED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take_exc && (exc_class == 3'd3)) |=> (vec_addr[ADDR_W-1:ADDR_W-3] == 3'b101)); // R4
  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ext_mode |-> (sw_req == '0 && !timer_req && !perf_req && !fdc_req)); // R9
endmodule

// File: tb/test_exc_vector_gen.sv
module test_exc_vector_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  exc_class;
  logic        take_exc, bev_we, bev_wd, int_vec, ext_mode;
  logic [2:0]  spacing;
  logic [5:0]  ext_level, hw_irq;
  logic [1:0]  sw_bits;
  logic        timer_irq, perf_irq, fdc_irq;
  logic [31:0] vec_addr;
  logic        vec_valid;
  logic [5:0]  cap_level;
  logic [1:0]  sw_req;
  logic        timer_req, perf_req, fdc_req;

  always #10 clk = ~clk;

  exc_vector_gen i_exc_vector_gen (
    .clk(clk), .rst_n(rst_n), .exc_class(exc_class), .take_exc(take_exc),
    .bev_we(bev_we), .bev_wd(bev_wd), .int_vec(int_vec), .ext_mode(ext_mode),
    .spacing(spacing), .ext_level(ext_level), .hw_irq(hw_irq), .sw_bits(sw_bits),
    .timer_irq(timer_irq), .perf_irq(perf_irq), .fdc_irq(fdc_irq),
    .vec_addr(vec_addr), .vec_valid(vec_valid), .cap_level(cap_level),
    .sw_req(sw_req), .timer_req(timer_req), .perf_req(perf_req), .fdc_req(fdc_req)
  );

  typedef struct {
    logic [31:0] addr;
    logic [5:0]  lvl;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails  = 0;
  int   takes  = 0;
  int   valids = 0;
  bit   done   = 0;
  logic bev_model;
  logic [5:0] lvl_model;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(input logic [2:0] c, input logic b);
    logic [31:0] base, step, idx;
    logic [7:0]  pend;
    base = b ? 32'hBFC0_0000 : 32'h8000_0000;
    if (spacing >= 3'd1 && spacing <= 3'd5) step = 32'd32 * (32'd1 << (spacing - 3'd1));
    else step = 0;
    pend = {hw_irq[5] | timer_irq | perf_irq | fdc_irq, hw_irq[4:0], sw_bits};
    idx = 0;
    if (ext_mode) idx = {26'd0, ext_level};
    else for (int i = 0; i < 8; i++) if (pend[i]) idx = i;
    case (c)
      3'd0, 3'd1, 3'd2: ref_addr = 32'hBFC0_0000;
      3'd3: ref_addr = (b ? 32'hBFC0_0000 : 32'hA000_0000) + 32'h100;
      3'd4: ref_addr = base;
      3'd5: ref_addr = int_vec ? base + 32'h200 + idx * step : base + 32'h180;
      default: ref_addr = base + 32'h180;
    endcase
  endfunction

  // Driver: called at a negedge, pushes the prediction and pulses take for one cycle.
  task automatic take(input logic [2:0] c, input string req);
    exp_t e;
    exc_class = c;
    e.addr = ref_addr(c, bev_model);
    lvl_model = ext_mode ? ext_level : 6'd0;
    e.lvl = lvl_model;
    e.req = req;
    sbq.push_back(e);
    takes++;
    take_exc = 1'b1;
    @(negedge clk);
    take_exc = 1'b0;
  endtask

  task automatic write_bev(input logic v);
    bev_we = 1'b1; bev_wd = v;
    @(negedge clk);
    bev_we = 1'b0;
    bev_model = v;
  endtask

  // Monitor: compares results as they appear.
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      valids++;
      if (sbq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 actual=valid expected=no result pending");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.req, " addr"}, vec_addr, e.addr);
        check({e.req, " level R7"}, {26'd0, cap_level}, {26'd0, e.lvl});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exc_class = 0; take_exc = 0; bev_we = 0; bev_wd = 0;
    int_vec = 0; ext_mode = 0; spacing = 0; ext_level = 0; hw_irq = 0;
    sw_bits = 0; timer_irq = 0; perf_irq = 0; fdc_irq = 0;
    bev_model = 1'b1; lvl_model = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 vec_addr", vec_addr, 32'hBFC0_0000);
    check("R1 cap_level", {26'd0, cap_level}, 32'd0);
    check("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
    take(3'd6, "R1 boot bit set");

    // R2 fixed entries, R3 R4 relocatable under bev=1
    take(3'd0, "R2 reset"); take(3'd1, "R2 nmi"); take(3'd2, "R2 debug");
    take(3'd4, "R3 tlb bev1"); take(3'd6, "R3 general bev1"); take(3'd7, "R3 spare bev1");
    take(3'd3, "R4 cerr bev1");
    // R11 then bev=0
    write_bev(1'b0);
    take(3'd4, "R11 tlb after write");
    take(3'd0, "R2 reset bev0"); take(3'd1, "R2 nmi bev0"); take(3'd2, "R2 debug bev0");
    take(3'd6, "R3 general bev0"); take(3'd3, "R4 cerr bev0");

    // R5 non-vectored interrupts
    int_vec = 0; ext_mode = 1; ext_level = 6'd9; spacing = 3'd2;
    take(3'd5, "R5 int ext");
    ext_mode = 0; hw_irq = 6'h3F;
    take(3'd5, "R5 int internal");
    hw_irq = 0;

    // R6 external-mode vectoring, all spacing codes, several levels
    int_vec = 1; ext_mode = 1;
    for (int s = 0; s < 8; s++) begin
      spacing = s[2:0];
      ext_level = 6'd63; take(3'd5, "R6 level63");
      ext_level = 6'd5;  take(3'd5, "R6 level5");
    end
    spacing = 3'd5; ext_level = 6'd0; take(3'd5, "R6 level0");
    ext_level = 6'd37; take(3'd5, "R6 level37");
    write_bev(1'b1);
    spacing = 3'd1; ext_level = 6'd37; take(3'd5, "R6 bev1");
    write_bev(1'b0);

    // R7 level held while input moves
    ext_level = 6'd21; take(3'd6, "R7 capture on general");
    ext_level = 6'd44;
    repeat (3) @(negedge clk);
    check("R7 level held", {26'd0, cap_level}, 32'd21);
    ext_mode = 0; take(3'd6, "R7 internal take clears");
    check("R7 cleared", {26'd0, cap_level}, 32'd0);

    // R8 internal priority
    int_vec = 1; ext_mode = 0; spacing = 3'd3;
    hw_irq = 0; sw_bits = 0; take(3'd5, "R8 none pending");
    sw_bits = 2'b01; take(3'd5, "R8 sw0");
    sw_bits = 2'b10; hw_irq = 6'b000100; take(3'd5, "R8 hw2 over sw1");
    sw_bits = 0; hw_irq = 6'b100000; take(3'd5, "R8 hw5");
    hw_irq = 0; timer_irq = 1; take(3'd5, "R8 timer top line");
    timer_irq = 0; fdc_irq = 1; take(3'd5, "R8 fdc top line");
    fdc_irq = 0; perf_irq = 1; hw_irq = 6'b011111; sw_bits = 2'b11; take(3'd5, "R8 all");
    spacing = 3'd0; take(3'd5, "R8 spacing0");
    perf_irq = 0; hw_irq = 0; sw_bits = 0;

    // R9 routing and sw bits ignored in external mode
    ext_mode = 1; sw_bits = 2'b10; timer_irq = 1; perf_irq = 0; fdc_irq = 1;
    #1;
    check("R9 sw_req ext", {30'd0, sw_req}, 32'd2);
    check("R9 lines ext", {29'd0, timer_req, perf_req, fdc_req}, 32'b101);
    timer_irq = 0; perf_irq = 1; fdc_irq = 0; sw_bits = 2'b01;
    #1;
    check("R9 lines ext b", {27'd0, sw_req, timer_req, perf_req, fdc_req}, 32'b01010);
    ext_mode = 0;
    #1;
    check("R9 quiet internal", {27'd0, sw_req, timer_req, perf_req, fdc_req}, 32'd0);
    @(negedge clk);
    ext_mode = 1; int_vec = 1; spacing = 3'd4; ext_level = 6'd3;
    sw_bits = 2'b00; take(3'd5, "R9 sw ignored a");
    sw_bits = 2'b11; take(3'd5, "R9 sw ignored b");
    sw_bits = 0; perf_irq = 0;

    // R10 back-to-back takes
    ext_level = 6'd1; take(3'd5, "R10 b2b 1");
    ext_level = 6'd2; take(3'd5, "R10 b2b 2");
    ext_level = 6'd3; take(3'd4, "R10 b2b 3");
    repeat (3) @(negedge clk);
    check("R10 valid count", valids, takes);
    check("R10 queue drained", sbq.size(), 0);
    check("R10 addr held", vec_addr, 32'h8000_0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule